// File: doc/BRIEF.md
# Two-Tone Quadrature FSK Demodulator

This block recovers data bits from a two-tone frequency-shift-keyed signal. A low tone (the space tone) stands for one symbol value and a high tone (the mark tone) for the other. Each incoming converter sample is multiplied by a cosine and a sine reference for each tone. That gives four channels: space in-phase (IS), space quadrature (QS), mark in-phase (IM) and mark quadrature (QM). The carrier references come from outside the block and are shared with the transmitter, so the block has no oscillator of its own.

Each channel's product passes through a moving-sum low-pass filter, a decimator and an absolute-value stage. The rectified values are then summed over one chip period. A chip strobe from the symbol-timing logic closes the period. On that strobe the four channel sums are published, the mark energy is compared with the space energy to give one bit, and the accumulators start again from zero. The filter history and the decimation phase carry on across chips.

Top module: `qfsk_demod`

## Requirements
- R1: While reset is held, and until the first chip strobe after reset, all four channel magnitudes, the decided bit and the bit-valid output read zero.
- R2: A sample is taken only in a cycle with the sample-valid input high. It is then multiplied, as signed two's-complement numbers, by the reference of each channel: ref_si_i gives IS, ref_sq_i gives QS, ref_mi_i gives IM and ref_mq_i gives QM.
- R3: Each channel's filtered value is the signed sum of its last WIN_LEN products. Before WIN_LEN products exist, the missing ones count as zero.
- R4: Each channel passes every DEC_FACTOR-th filtered value, counting filtered values from reset (the DEC_FACTOR-th, the 2·DEC_FACTOR-th, and so on). The decimation phase is not reset by the chip strobe.
- R5: Each decimated value is rectified to its absolute value before accumulation.
- R6: On a chip strobe, each channel magnitude output takes the sum of all rectified values produced since the previous strobe, including one produced in the strobe cycle itself. The running sum then restarts at zero.
- R7: The bit published with a chip strobe is 1 when mag_im_o + mag_qm_o is strictly greater than mag_is_o + mag_qs_o, and 0 otherwise. A tie gives 0.
- R8: bit_valid_o is high for exactly the one cycle after each clock edge that samples chip_stb_i high, and low otherwise. Strobes on consecutive cycles give consecutive valid cycles.
- R9: The magnitudes and the decided bit keep their values between chip strobes, whatever samples arrive in the meantime.
- R10: A chip of up to MAX_DEC_PER_CHIP decimated values, all at full scale (both operands at the most negative code), is summed without wrap-around.
- R11: Sample and reference values presented while the sample-valid input is low have no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_i | input | SMP_W | Signed converter sample |
| ref_si_i | input | REF_W | Signed space-tone in-phase reference |
| ref_sq_i | input | REF_W | Signed space-tone quadrature reference |
| ref_mi_i | input | REF_W | Signed mark-tone in-phase reference |
| ref_mq_i | input | REF_W | Signed mark-tone quadrature reference |
| chip_stb_i | input | 1 | Chip period boundary strobe |
| mag_is_o | output | ACC_W | Accumulated space in-phase magnitude |
| mag_qs_o | output | ACC_W | Accumulated space quadrature magnitude |
| mag_im_o | output | ACC_W | Accumulated mark in-phase magnitude |
| mag_qm_o | output | ACC_W | Accumulated mark quadrature magnitude |
| bit_o | output | 1 | Decided data bit |
| bit_valid_o | output | 1 | One-cycle pulse marking a new decision |

## Verification
A sample takes four clock edges to reach a channel's running sum: one each for the mixer, the moving sum, the decimator and the rectifier. It joins the sum at the fifth edge. The magnitudes, the bit and the valid pulse all change at the edge that samples the strobe. So the bench drives inputs on falling edges and lets eight idle cycles pass after the last sample of a chip before it raises the strobe. It reads every result at the next falling edge and checks that the valid pulse has dropped one cycle later. Between strobes the outputs are read on every cycle of a sample burst to show that they hold.

// File: rtl/qfsk_pkg.sv
package qfsk_pkg;

  localparam int NUM_CH = 4;

  // Channel slots; the decision logic pairs them by tone.
  localparam int CH_IS = 0;
  localparam int CH_QS = 1;
  localparam int CH_IM = 2;
  localparam int CH_QM = 3;

  function automatic int unsigned cnt_width(input int unsigned span);
    return (span > 1) ? $clog2(span) : 1;
  endfunction

endpackage

// File: rtl/qfsk_mix_filter.sv
module qfsk_mix_filter #(
  parameter int SMP_W   = 8,
  parameter int REF_W   = 8,
  parameter int WIN_LEN = 4,
  parameter int PROD_W  = SMP_W + REF_W,
  parameter int SUM_W   = PROD_W + $clog2(WIN_LEN) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic                    vld_o,
  output logic signed [SUM_W-1:0] sum_o
);

  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic                     prod_vld_q;
  logic signed [PROD_W-1:0] tap_d [WIN_LEN];
  logic signed [PROD_W-1:0] tap_q [WIN_LEN];
  logic signed [SUM_W-1:0]  sum_d, sum_q;
  logic                     sum_vld_q;

  // Next state: product, shifted window and running sum.
  always_comb begin
    prod_d = PROD_W'(smp_i) * PROD_W'(ref_i);
    tap_d[0] = prod_q;
    for (int i = 1; i < WIN_LEN; i++) begin
      tap_d[i] = tap_q[i-1];
    end
    sum_d = sum_q + SUM_W'(prod_q) - SUM_W'(tap_q[WIN_LEN-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q     <= '0;
      prod_vld_q <= 1'b0;
      sum_q      <= '0;
      sum_vld_q  <= 1'b0;
      for (int i = 0; i < WIN_LEN; i++) begin
        tap_q[i] <= '0;
      end
    end else begin
      prod_vld_q <= vld_i;
      sum_vld_q  <= prod_vld_q;
      if (vld_i) begin
        prod_q <= prod_d;
      end
      if (prod_vld_q) begin
        sum_q <= sum_d;
        tap_q <= tap_d;
      end
    end
  end

  assign vld_o = sum_vld_q;
  assign sum_o = sum_q;

endmodule

// File: rtl/qfsk_decim_rect.sv
module qfsk_decim_rect #(
  parameter int SUM_W      = 19,
  parameter int DEC_FACTOR = 2,
  parameter int MAG_W      = SUM_W - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic                    vld_o,
  output logic [MAG_W-1:0]        mag_o
);

  import qfsk_pkg::*;

  logic                    hit;
  logic signed [SUM_W-1:0] dec_q;
  logic                    dec_vld_q;
  logic signed [SUM_W-1:0] neg_val;
  logic [MAG_W-1:0]        mag_d, mag_q;
  logic                    mag_vld_q;

  generate
    if (DEC_FACTOR == 1) begin : g_pass
      assign hit = 1'b1;
    end else begin : g_count
      localparam int CNT_W = cnt_width(DEC_FACTOR);
      logic [CNT_W-1:0] cnt_d, cnt_q;

      always_comb begin
        cnt_d = hit ? '0 : cnt_q + 1'b1;
      end

      assign hit = (cnt_q == CNT_W'(DEC_FACTOR - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (vld_i) begin
          cnt_q <= cnt_d;
        end
      end
    end
  endgenerate

  // Rectifier next state.
  always_comb begin
    neg_val = -dec_q;
    mag_d   = dec_q[SUM_W-1] ? MAG_W'(neg_val) : MAG_W'(dec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q     <= '0;
      dec_vld_q <= 1'b0;
      mag_q     <= '0;
      mag_vld_q <= 1'b0;
    end else begin
      dec_vld_q <= vld_i && hit;
      mag_vld_q <= dec_vld_q;
      if (vld_i && hit) begin
        dec_q <= sum_i;
      end
      if (dec_vld_q) begin
        mag_q <= mag_d;
      end
    end
  end

  assign vld_o = mag_vld_q;
  assign mag_o = mag_q;

endmodule

// File: rtl/qfsk_accum.sv
module qfsk_accum #(
  parameter int MAG_W = 18,
  parameter int ACC_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             chip_stb_i,
  output logic [ACC_W-1:0] run_o,
  output logic [ACC_W-1:0] close_o,
  output logic [ACC_W-1:0] res_o
);

  logic [ACC_W-1:0] acc_d, acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] res_q;
  logic             acc_en;

  always_comb begin
    acc_sum = acc_q + (vld_i ? ACC_W'(mag_i) : '0);
    acc_d   = chip_stb_i ? '0 : acc_sum;
    acc_en  = vld_i || chip_stb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (acc_en) begin
        acc_q <= acc_d;
      end
      if (chip_stb_i) begin
        res_q <= acc_sum;
      end
    end
  end

  assign run_o   = acc_q;
  assign close_o = acc_sum;
  assign res_o   = res_q;

endmodule

// File: rtl/qfsk_decide.sv
module qfsk_decide #(
  parameter int ACC_W = 23
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  chip_stb_i,
  input  logic [qfsk_pkg::NUM_CH-1:0][ACC_W-1:0] close_i,
  output logic                                  bit_o,
  output logic                                  bit_valid_o
);

  import qfsk_pkg::*;

  logic [ACC_W:0] mark_sum, space_sum;
  logic           bit_d, bit_q, vld_q;

  always_comb begin
    mark_sum  = {1'b0, close_i[CH_IM]} + {1'b0, close_i[CH_QM]};
    space_sum = {1'b0, close_i[CH_IS]} + {1'b0, close_i[CH_QS]};
    bit_d     = mark_sum > space_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= chip_stb_i;
      if (chip_stb_i) begin
        bit_q <= bit_d;
      end
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = vld_q;

endmodule

// File: rtl/qfsk_demod.sv
module qfsk_demod #(
  parameter int SMP_W            = 8,
  parameter int REF_W            = 8,
  parameter int WIN_LEN          = 4,
  parameter int DEC_FACTOR       = 2,
  parameter int MAX_DEC_PER_CHIP = 16,
  localparam int PROD_W          = SMP_W + REF_W,
  localparam int SUM_W           = PROD_W + $clog2(WIN_LEN) + 1,
  localparam int MAG_W           = SUM_W - 1,
  localparam int ACC_W           = MAG_W + $clog2(MAX_DEC_PER_CHIP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [REF_W-1:0] ref_si_i,
  input  logic signed [REF_W-1:0] ref_sq_i,
  input  logic signed [REF_W-1:0] ref_mi_i,
  input  logic signed [REF_W-1:0] ref_mq_i,
  input  logic                    chip_stb_i,
  output logic [ACC_W-1:0]        mag_is_o,
  output logic [ACC_W-1:0]        mag_qs_o,
  output logic [ACC_W-1:0]        mag_im_o,
  output logic [ACC_W-1:0]        mag_qm_o,
  output logic                    bit_o,
  output logic                    bit_valid_o
);

  import qfsk_pkg::*;

  // Reset: asserted at once, released on the clock.
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic signed [NUM_CH-1:0][REF_W-1:0] ref_arr;
  logic [NUM_CH-1:0]                   filt_vld;
  logic signed [SUM_W-1:0]             filt_sum [NUM_CH];
  logic [NUM_CH-1:0]                   abs_vld;
  logic [MAG_W-1:0]                    abs_mag  [NUM_CH];
  logic [NUM_CH-1:0][ACC_W-1:0]        acc_run;
  logic [NUM_CH-1:0][ACC_W-1:0]        acc_close;
  logic [NUM_CH-1:0][ACC_W-1:0]        acc_res;

  assign ref_arr[CH_IS] = ref_si_i;
  assign ref_arr[CH_QS] = ref_sq_i;
  assign ref_arr[CH_IM] = ref_mi_i;
  assign ref_arr[CH_QM] = ref_mq_i;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      qfsk_mix_filter #(
        .SMP_W(SMP_W), .REF_W(REF_W), .WIN_LEN(WIN_LEN),
        .PROD_W(PROD_W), .SUM_W(SUM_W)
      ) u_mixf (
        .clk   (clk),
        .rst_n (rst_s),
        .vld_i (smp_vld_i),
        .smp_i (smp_i),
        .ref_i (ref_arr[c]),
        .vld_o (filt_vld[c]),
        .sum_o (filt_sum[c])
      );

      qfsk_decim_rect #(
        .SUM_W(SUM_W), .DEC_FACTOR(DEC_FACTOR), .MAG_W(MAG_W)
      ) u_decr (
        .clk   (clk),
        .rst_n (rst_s),
        .vld_i (filt_vld[c]),
        .sum_i (filt_sum[c]),
        .vld_o (abs_vld[c]),
        .mag_o (abs_mag[c])
      );

      qfsk_accum #(
        .MAG_W(MAG_W), .ACC_W(ACC_W)
      ) u_acc (
        .clk        (clk),
        .rst_n      (rst_s),
        .vld_i      (abs_vld[c]),
        .mag_i      (abs_mag[c]),
        .chip_stb_i (chip_stb_i),
        .run_o      (acc_run[c]),
        .close_o    (acc_close[c]),
        .res_o      (acc_res[c])
      );
    end
  endgenerate

  qfsk_decide #(
    .ACC_W(ACC_W)
  ) u_decide (
    .clk         (clk),
    .rst_n       (rst_s),
    .chip_stb_i  (chip_stb_i),
    .close_i     (acc_close),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o)
  );

  assign mag_is_o = acc_res[CH_IS];
  assign mag_qs_o = acc_res[CH_QS];
  assign mag_im_o = acc_res[CH_IM];
  assign mag_qm_o = acc_res[CH_QM];

endmodule

// File: rtl/qfsk_demod_chk.sv
module qfsk_demod_chk #(
  parameter int ACC_W  = 23,
  parameter int NUM_CH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         chip_stb_i,
  input logic                         bit_o,
  input logic                         bit_valid_o,
  input logic [ACC_W-1:0]             mag_is_o,
  input logic [ACC_W-1:0]             mag_qs_o,
  input logic [ACC_W-1:0]             mag_im_o,
  input logic [ACC_W-1:0]             mag_qm_o,
  input logic [NUM_CH-1:0]            abs_vld,
  input logic [NUM_CH-1:0][ACC_W-1:0] acc_run
);

  logic [ACC_W:0] mark_pub, space_pub;
  assign mark_pub  = {1'b0, mag_im_o} + {1'b0, mag_qm_o};
  assign space_pub = {1'b0, mag_is_o} + {1'b0, mag_qs_o};

  // R8: a strobe is followed by a valid cycle.
  p_valid_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb_i |=> bit_valid_o);

  // R8: no valid cycle without a strobe before it.
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_stb_i |=> !bit_valid_o);

  // R7: the published bit agrees with the published magnitudes.
  p_bit_decision_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> (bit_o == (mark_pub > space_pub)));

  // R9: results hold between strobes.
  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_stb_i |=> ($stable(mag_is_o) && $stable(mag_qs_o) &&
                     $stable(mag_im_o) && $stable(mag_qm_o) && $stable(bit_o)));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      // R6: the running sum restarts at zero after a strobe.
      p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chip_stb_i |=> (acc_run[c] == '0));

      // R10: adding a magnitude never makes the running sum smaller.
      p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_vld[c] && !chip_stb_i) |=> (acc_run[c] >= $past(acc_run[c])));
    end
  endgenerate

endmodule

bind qfsk_demod qfsk_demod_chk #(
  .ACC_W  (ACC_W),
  .NUM_CH (qfsk_pkg::NUM_CH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .chip_stb_i  (chip_stb_i),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .mag_is_o    (mag_is_o),
  .mag_qs_o    (mag_qs_o),
  .mag_im_o    (mag_im_o),
  .mag_qm_o    (mag_qm_o),
  .abs_vld     (abs_vld),
  .acc_run     (acc_run)
);

// File: tb/test_qfsk_demod.sv
module test_qfsk_demod;

  localparam int SMP_W = 8;
  localparam int REF_W = 8;
  localparam int WIN_LEN = 4;
  localparam int DEC_FACTOR = 2;
  localparam int MAX_DEC = 16;
  localparam int ACC_W = SMP_W + REF_W + $clog2(WIN_LEN) + $clog2(MAX_DEC + 1);

  logic clk;
  logic rst_n;
  logic smp_vld;
  logic signed [SMP_W-1:0] smp;
  logic signed [REF_W-1:0] r_si, r_sq, r_mi, r_mq;
  logic chip_stb;
  logic [ACC_W-1:0] m_is, m_qs, m_im, m_qm;
  logic bit_out, bit_vld;

  qfsk_demod #(
    .SMP_W(SMP_W), .REF_W(REF_W), .WIN_LEN(WIN_LEN),
    .DEC_FACTOR(DEC_FACTOR), .MAX_DEC_PER_CHIP(MAX_DEC)
  ) i_qfsk_demod (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_i(smp),
    .ref_si_i(r_si), .ref_sq_i(r_sq), .ref_mi_i(r_mi), .ref_mq_i(r_mq),
    .chip_stb_i(chip_stb),
    .mag_is_o(m_is), .mag_qs_o(m_qs), .mag_im_o(m_im), .mag_qm_o(m_qm),
    .bit_o(bit_out), .bit_valid_o(bit_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;

  longint hist [4][WIN_LEN];
  int     dcnt [4];
  longint acc_m [4];
  longint last_mag [4];
  bit     last_bit;

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model: multiply, window sum, decimate, rectify, accumulate.
  task automatic model_step(input int s, input int r0, input int r1, input int r2, input int r3);
    int rr[4];
    rr = '{r0, r1, r2, r3};
    for (int c = 0; c < 4; c++) begin
      longint f;
      for (int i = WIN_LEN - 1; i > 0; i--) hist[c][i] = hist[c][i-1];
      hist[c][0] = longint'(s) * longint'(rr[c]);
      f = 0;
      for (int i = 0; i < WIN_LEN; i++) f += hist[c][i];
      if (dcnt[c] == DEC_FACTOR - 1) begin
        acc_m[c] += (f < 0) ? -f : f;
        dcnt[c] = 0;
      end else begin
        dcnt[c]++;
      end
    end
  endtask

  task automatic push(input bit v, input int s, input int r0, input int r1, input int r2, input int r3);
    smp_vld = v;
    smp  = SMP_W'(s);
    r_si = REF_W'(r0);
    r_sq = REF_W'(r1);
    r_mi = REF_W'(r2);
    r_mq = REF_W'(r3);
    if (v) model_step(s, r0, r1, r2, r3);
    @(negedge clk);
  endtask

  // Idle cycles carry junk data with valid low (R11).
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) push(1'b0, rnd8(), rnd8(), rnd8(), rnd8(), rnd8());
  endtask

  task automatic strobe_check(input string tag);
    idle(8);
    for (int c = 0; c < 4; c++) begin
      last_mag[c] = acc_m[c];
      acc_m[c] = 0;
    end
    last_bit = (last_mag[2] + last_mag[3]) > (last_mag[0] + last_mag[1]);
    chip_stb = 1'b1;
    @(negedge clk);
    chip_stb = 1'b0;
    chk({tag, " R6 R2 R3 R4 R5 IS"}, longint'(m_is), last_mag[0]);
    chk({tag, " R6 R2 R3 R4 R5 QS"}, longint'(m_qs), last_mag[1]);
    chk({tag, " R6 R2 R3 R4 R5 IM"}, longint'(m_im), last_mag[2]);
    chk({tag, " R6 R2 R3 R4 R5 QM"}, longint'(m_qm), last_mag[3]);
    chk({tag, " R7 bit"}, longint'(bit_out), longint'(last_bit));
    chk({tag, " R8 valid high"}, longint'(bit_vld), 1);
    @(negedge clk);
    chk({tag, " R8 valid low"}, longint'(bit_vld), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < WIN_LEN; i++) hist[c][i] = 0;
      dcnt[c] = 0;
      acc_m[c] = 0;
    end
    rst_n = 1'b0;
    smp_vld = 1'b0; smp = '0; r_si = '0; r_sq = '0; r_mi = '0; r_mq = '0;
    chip_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset IS", longint'(m_is), 0);
    chk("R1 reset bit_valid", longint'(bit_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle IS", longint'(m_is), 0);
    chk("R1 idle QS", longint'(m_qs), 0);
    chk("R1 idle IM", longint'(m_im), 0);
    chk("R1 idle QM", longint'(m_qm), 0);
    chk("R1 idle bit", longint'(bit_out), 0);
    chk("R1 idle bit_valid", longint'(bit_vld), 0);

    // Pseudo-random chips of varying length, junk cycles mixed in (R11).
    for (int ch = 0; ch < 14; ch++) begin
      int len;
      len = 3 + (ch * 7) % 30;
      for (int k = 0; k < len; k++) begin
        push(1'b1, rnd8(), rnd8(), rnd8(), rnd8(), rnd8());
        if (seed[28]) idle(1 + int'(seed[30:29]));
      end
      strobe_check("random chip");
    end

    // Full-scale chip, MAX_DEC decimated values (R10).
    for (int k = 0; k < MAX_DEC * DEC_FACTOR; k++) push(1'b1, -128, -128, -128, -128, -128);
    strobe_check("R10 full scale");

    // Tie between tones gives 0 (R7).
    for (int k = 0; k < 20; k++) begin
      int a, b;
      a = rnd8(); b = rnd8();
      push(1'b1, rnd8(), a, b, a, b);
    end
    strobe_check("R7 tie");

    // Mark tone only, then space tone only (R7).
    for (int k = 0; k < 12; k++) push(1'b1, rnd8(), 0, 0, rnd8(), rnd8());
    strobe_check("R7 mark");
    for (int k = 0; k < 12; k++) push(1'b1, rnd8(), rnd8(), rnd8(), 0, 0);
    strobe_check("R7 space");

    // Results hold while a new chip streams in (R9).
    for (int k = 0; k < 10; k++) begin
      push(1'b1, rnd8(), rnd8(), rnd8(), rnd8(), rnd8());
      chk("R9 hold IS", longint'(m_is), last_mag[0]);
      chk("R9 hold QM", longint'(m_qm), last_mag[3]);
      chk("R9 hold bit", longint'(bit_out), longint'(last_bit));
    end
    strobe_check("R9 after hold");

    // Empty chip, then strobes on two consecutive cycles (R8).
    strobe_check("R6 empty chip");
    chip_stb = 1'b1;
    @(negedge clk);
    chk("R8 back-to-back first", longint'(bit_vld), 1);
    @(negedge clk);
    chip_stb = 1'b0;
    chk("R8 back-to-back second", longint'(bit_vld), 1);
    chk("R6 back-to-back IM", longint'(m_im), 0);
    @(negedge clk);
    chk("R8 back-to-back end", longint'(bit_vld), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule